// File: doc/BRIEF.md
# Program Address Sequencer

This block forms the address presented to the program ROM of a small processor. It holds a 12-bit program counter that normally advances one step per enabled cycle. It also holds a separate jump-target register that can be written either from a byte read out of the program ROM or from a full word read out of the scratch-pad RAM. A jump copies that register into the counter.

The ROM address leaving the block can bypass the counter entirely. In that case it comes straight from the accumulator value. Programs use this to index data tables held in ROM and to branch to addresses they have computed. Instruction decoding and the ROM array are outside this block. The surrounding sequencer drives the strobes and the data, and this block only keeps and routes addresses.

Top module: `prog_addr_seq`

## Requirements
- R1: While reset (active low `rstN`) is asserted, the counter and the jump-target register are both 0, so the ROM address is 0 when the counter is selected. The target stays 0 after reset until it is written.
- R2: With `incEn`=1 and `jumpEn`=0 the counter advances by one on each clock. It wraps from 4095 to 0.
- R3: With `jumpEn`=1 the counter takes the value the jump-target register held before that clock edge.
- R4: When `jumpEn` and `incEn` are both 1 in the same cycle, the jump wins and no increment is applied.
- R5: With `incEn`=0 and `jumpEn`=0 the counter keeps its value.
- R6: With `tgtLoadEn`=1 and `tgtSrcRam`=0 the target register takes the 8-bit `romData`, zero-extended. Bits 11..8 become 0.
- R7: With `tgtLoadEn`=1 and `tgtSrcRam`=1 the target register takes the full 12-bit `ramData`.
- R8: `romAddr` equals `accValue` when `addrFromAcc`=1 and equals the counter when `addrFromAcc`=0, with no clock delay.
- R9: The value of `addrFromAcc` has no effect on the counter. The counter still holds or steps exactly as R2 and R5 state.
- R10: With `tgtLoadEn`=0 the target register holds its value. Writing the target leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| incEn | input | 1 | Step the counter |
| jumpEn | input | 1 | Load the counter from the jump target |
| tgtLoadEn | input | 1 | Write the jump-target register |
| tgtSrcRam | input | 1 | Target source: 1 selects RAM word, 0 selects ROM byte |
| romData | input | 8 | Byte from program ROM |
| ramData | input | 12 | Word from scratch-pad RAM |
| accValue | input | 12 | Current accumulator value |
| addrFromAcc | input | 1 | 1 routes the accumulator to the ROM address |
| romAddr | output | 12 | Program ROM address |

## Verification
Some rules are checked by assertions on every cycle:
- a jump puts the previous target into the counter;
- a plain step adds one, modulo the counter width;
- an idle cycle leaves the counter unchanged;
- a jump never happens together with a step;
- a ROM-sourced target has zero upper bits.

Other behaviour shows up only in the bench's scenarios:
- whether the selector really bypasses the counter, for every accumulator value;
- the ordering when a target write and a jump fall in the same cycle;
- that the counter keeps its value while the accumulator drives the address;
- the full wrap around all 4096 addresses.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;
  parameter int ADDR_W = 12;
  parameter int ROM_W  = 8;

  typedef struct packed {
    logic pcLoad;
    logic pcStep;
    logic tgtWrite;
    logic tgtFromRam;
    logic addrFromAcc;
  } seqCtl_t;
endpackage

// File: rtl/prog_addr_ctl.sv
module prog_addr_ctl
  import prog_addr_pkg::*;
(
  input  logic    incEn,
  input  logic    jumpEn,
  input  logic    tgtLoadEn,
  input  logic    tgtSrcRam,
  input  logic    addrFromAcc,
  output seqCtl_t ctl
);
  // A jump overrides a step in the same cycle (R4)
  always_comb begin
    ctl.pcLoad      = jumpEn;
    ctl.pcStep      = incEn & ~jumpEn;
    ctl.tgtWrite    = tgtLoadEn;
    ctl.tgtFromRam  = tgtSrcRam;
    ctl.addrFromAcc = addrFromAcc;
  end
endmodule

// File: rtl/prog_addr_dp.sv
module prog_addr_dp
  import prog_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = ROM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtl_t       ctl,
  input  logic [BW-1:0] romData,
  input  logic [AW-1:0] ramData,
  input  logic [AW-1:0] accValue,
  output logic [AW-1:0] romAddr
);
  localparam int PAD_W = AW - BW;

  logic [AW-1:0] pcQ;
  logic [AW-1:0] tgtQ;
  logic [AW-1:0] romWide;

  generate
    if (PAD_W > 0) begin : g_pad
      assign romWide = {{PAD_W{1'b0}}, romData};
    end else begin : g_trim
      assign romWide = romData[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ <= '0;
    end else if (ctl.tgtWrite) begin
      tgtQ <= ctl.tgtFromRam ? ramData : romWide;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (ctl.pcLoad) begin
      pcQ <= tgtQ;
    end else if (ctl.pcStep) begin
      pcQ <= pcQ + 1'b1;
    end
  end

  assign romAddr = ctl.addrFromAcc ? accValue : pcQ;

  AST_JUMP_TAKES_TGT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcLoad |=> pcQ == $past(tgtQ)); // R3
  AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcStep |=> pcQ == AW'($past(pcQ) + 1'b1)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.pcLoad && !ctl.pcStep) |=> $stable(pcQ)); // R5
  AST_NO_DOUBLE_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcLoad |-> !ctl.pcStep); // R4
  AST_TGT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.tgtWrite |=> $stable(tgtQ)); // R10

  generate
    if (PAD_W > 0) begin : g_padChk
      AST_ROM_TGT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.tgtWrite && !ctl.tgtFromRam) |=> tgtQ[AW-1:BW] == '0); // R6
    end
  endgenerate
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
  import prog_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              incEn,
  input  logic              jumpEn,
  input  logic              tgtLoadEn,
  input  logic              tgtSrcRam,
  input  logic [ROM_W-1:0]  romData,
  input  logic [ADDR_W-1:0] ramData,
  input  logic [ADDR_W-1:0] accValue,
  input  logic              addrFromAcc,
  output logic [ADDR_W-1:0] romAddr
);
  seqCtl_t ctl;

  prog_addr_ctl u_ctl (
    .incEn(incEn), .jumpEn(jumpEn), .tgtLoadEn(tgtLoadEn),
    .tgtSrcRam(tgtSrcRam), .addrFromAcc(addrFromAcc), .ctl(ctl)
  );

  prog_addr_dp #(.AW(ADDR_W), .BW(ROM_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .romData(romData),
    .ramData(ramData), .accValue(accValue), .romAddr(romAddr)
  );
endmodule

// File: tb/sim_prog_addr_seq.sv
module sim_prog_addr_seq;
  logic        clk = 1'b0;
  logic        rstN;
  logic        incEn, jumpEn, tgtLoadEn, tgtSrcRam, addrFromAcc;
  logic [7:0]  romData;
  logic [11:0] ramData, accValue, romAddr;
  int          nChecks = 0;
  int          nErrors = 0;
  logic [11:0] expPc;

  always #4 clk = ~clk;

  prog_addr_seq u0 (
    .clk(clk), .rstN(rstN), .incEn(incEn), .jumpEn(jumpEn),
    .tgtLoadEn(tgtLoadEn), .tgtSrcRam(tgtSrcRam), .romData(romData),
    .ramData(ramData), .accValue(accValue), .addrFromAcc(addrFromAcc),
    .romAddr(romAddr)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    incEn = 0; jumpEn = 0; tgtLoadEn = 0; tgtSrcRam = 0; addrFromAcc = 0;
  endtask

  initial begin
    #(8 * 200000);
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    idle();
    romData = 8'h00; ramData = '0; accValue = '0;
    rstN = 0;
    tick(); tick();
    chk("R1 reset counter", romAddr, 12'd0);
    rstN = 1;
    tick();
    chk("R1 after reset", romAddr, 12'd0);

    // R1: target resets to 0 - step away, then jump back
    incEn = 1;
    repeat (5) tick();
    incEn = 0;
    chk("R2 five steps", romAddr, 12'd5);
    jumpEn = 1; tick(); jumpEn = 0;
    chk("R1 target reset zero", romAddr, 12'd0);

    // R2: full sweep and wrap
    expPc = 12'd0;
    incEn = 1;
    for (int i = 0; i < 4097; i++) begin
      tick();
      expPc = expPc + 12'd1;
      chk("R2 step/wrap", romAddr, expPc);
    end
    incEn = 0;

    // R5: hold
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 hold", romAddr, expPc);
    end

    // R7 and R10: RAM-sourced targets
    for (int i = 0; i < 64; i++) begin
      logic [11:0] v;
      v = 12'((i * 67 + 11) & 12'hFFF);
      tgtLoadEn = 1; tgtSrcRam = 1; ramData = v; romData = 8'hA5;
      tick();
      tgtLoadEn = 0; ramData = ~v;
      chk("R10 load leaves counter", romAddr, expPc);
      tick();
      chk("R10 target holds", romAddr, expPc);
      jumpEn = 1; tick(); jumpEn = 0;
      expPc = v;
      chk("R7 ram target jump", romAddr, expPc);
    end

    // R6: every ROM byte, zero-extended
    for (int b = 0; b < 256; b++) begin
      tgtLoadEn = 1; tgtSrcRam = 0; romData = 8'(b); ramData = 12'hFFF;
      tick();
      tgtLoadEn = 0;
      jumpEn = 1; tick(); jumpEn = 0;
      expPc = 12'(b);
      chk("R6 rom target zero-ext", romAddr, expPc);
    end

    // R4: jump beats increment
    tgtLoadEn = 1; tgtSrcRam = 1; ramData = 12'h123; tick(); tgtLoadEn = 0;
    jumpEn = 1; incEn = 1; tick(); jumpEn = 0; incEn = 0;
    chk("R4 jump priority", romAddr, 12'h123);
    incEn = 1; tick(); incEn = 0;
    chk("R2 step after jump", romAddr, 12'h124);

    // R10 / R3: write and jump together uses previous target
    tgtLoadEn = 1; tgtSrcRam = 1; ramData = 12'h456; jumpEn = 1; tick();
    tgtLoadEn = 0; jumpEn = 0;
    chk("R3 jump uses old target", romAddr, 12'h123);
    jumpEn = 1; tick(); jumpEn = 0;
    chk("R3 new target after write", romAddr, 12'h456);
    expPc = 12'h456;

    // R8: every accumulator value routed combinationally
    addrFromAcc = 1;
    for (int a = 0; a < 4096; a++) begin
      accValue = 12'(a);
      #1;
      chk("R8 acc bypass", romAddr, 12'(a));
    end

    // R9: counter unaffected while accumulator selected
    accValue = 12'h0F0;
    tick(); tick();
    addrFromAcc = 0; #1;
    chk("R9 hold with acc selected", romAddr, expPc);
    addrFromAcc = 1; incEn = 1;
    repeat (3) tick();
    incEn = 0;
    chk("R8 acc still drives", romAddr, 12'h0F0);
    addrFromAcc = 0; #1;
    chk("R9 step with acc selected", romAddr, 12'(expPc + 12'd3));

    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule